// File: doc/BRIEF.md
# DTMF Tone Synthesizer with Burst Timer

This block produces a digital dual-tone multi-frequency sample stream for an external DAC. A 4-bit digit code chooses one of four row tones and one of four column tones. Each tone path runs a programmable divider whose terminal count sets how long each segment lasts. A 5-bit segment counter steps through a 32-point sine period read from a small table. The row and column samples are weighted, summed around mid-scale and registered onto the output word. The column tone carries about 2 dB more amplitude than the row tone.

The mode inputs come from a host-side control register. `tone_en` gates the output. `burst_mode` selects timed bursts. `single_tone` and `col_sel` pick one group only. `cp_mode` doubles the burst length. In burst mode an accepted write starts a burst of `BURST_TICKS` clocks followed by a silent pause of the same length. A one-cycle `tx_ready` pulse then marks that another code may be written. At the default 3.579545 MHz clock, `BURST_TICKS` = 182557 gives 51 ms. Writes that arrive during a burst or a pause are dropped.

Top module: `dtmf_synth`

## Requirements
- R1: A code is accepted when `wr_en` is high, unless a burst or pause is running in burst mode. The code selects a row r and a column c, with index 0 for the lowest frequency. The mapping is: 1→(0,0), 2→(0,1), 3→(0,2), 4→(1,0), 5→(1,1), 6→(1,2), 7→(2,0), 8→(2,1), 9→(2,2), 10→(3,1), 11→(3,0), 12→(3,2), 13→(0,3), 14→(1,3), 15→(2,3), 0→(3,3).
- R2: One sine period of a group spans exactly 32 segments of N clocks each, so it lasts 32·N clocks. The row counts N are 160, 146, 132 and 118. The column counts N are 92, 84, 76 and 68.
- R3: With `single_tone`=1, only the row group sounds when `col_sel`=0, and only the column group sounds when `col_sel`=1.
- R4: The sample is unsigned, with mid-scale 2^(SAMPLE_W-1) = 512. A lone row tone swings between 512−79 and 512+79. A lone column tone swings between 512−100 and 512+100.
- R5: Whenever `tone_active` is low, `sample_out` equals 512 on the next cycle.
- R6: With `burst_mode`=0, `tone_active` follows `tone_en` one cycle later.
- R7: With `burst_mode`=1 and `cp_mode`=0, an accepted write at clock edge E holds `tone_active` high for BURST_TICKS cycles. It then stays low for a pause of the same length. `tx_ready` is high for exactly one cycle, after edge E+2·BURST_TICKS.
- R8: With `cp_mode`=1 in burst mode, the burst and the pause each last 2·BURST_TICKS cycles, and `tx_ready` rises after edge E+4·BURST_TICKS.
- R9: A write during a burst or a pause in burst mode does not change the selected code, and it does not restart the timer.
- R10: While `rst` is high, `sample_out`=512, `tone_active`=0 and `tx_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `wr_code` |
| wr_code | input | 4 | Digit code |
| tone_en | input | 1 | Output enable |
| burst_mode | input | 1 | 1 = timed burst and pause |
| single_tone | input | 1 | 1 = one group only |
| col_sel | input | 1 | Group used in single-tone mode (0 row, 1 column) |
| cp_mode | input | 1 | Doubles burst and pause length |
| sample_out | output | SAMPLE_W | Unsigned DAC sample |
| tone_active | output | 1 | Output gate is open |
| tx_ready | output | 1 | One-cycle pulse at end of pause |

## Verification
The following properties are checked on every cycle. Each divider stays below its terminal count, and the segment counter moves only on a divider wrap or a restart. The output rests at mid-scale whenever the gate is closed. `tx_ready` lasts one cycle and follows a pause, and the code register does not change on a write during a busy period. Other behaviour can only be shown by the bench's scenarios. These are the code-to-frequency mapping measured as waveform periods, the row and column peak amplitudes, the exact burst and ready timing in both length modes, and the proof that a dropped write leaves the earlier tone sounding.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int NUM_GROUPS = 2;
  localparam int PHASE_W    = 5;
  localparam int DIV_W      = 8;
  localparam int MAG_W      = 7;
  localparam int AMP_W      = MAG_W + 2;

  typedef struct packed {
    logic [1:0] row;
    logic [1:0] col;
  } tone_sel_t;

  function automatic tone_sel_t decode_digit(input logic [3:0] code);
    tone_sel_t s;
    case (code)
      4'd1:  s = '{row: 2'd0, col: 2'd0};
      4'd2:  s = '{row: 2'd0, col: 2'd1};
      4'd3:  s = '{row: 2'd0, col: 2'd2};
      4'd4:  s = '{row: 2'd1, col: 2'd0};
      4'd5:  s = '{row: 2'd1, col: 2'd1};
      4'd6:  s = '{row: 2'd1, col: 2'd2};
      4'd7:  s = '{row: 2'd2, col: 2'd0};
      4'd8:  s = '{row: 2'd2, col: 2'd1};
      4'd9:  s = '{row: 2'd2, col: 2'd2};
      4'd10: s = '{row: 2'd3, col: 2'd1};
      4'd11: s = '{row: 2'd3, col: 2'd0};
      4'd12: s = '{row: 2'd3, col: 2'd2};
      4'd13: s = '{row: 2'd0, col: 2'd3};
      4'd14: s = '{row: 2'd1, col: 2'd3};
      4'd15: s = '{row: 2'd2, col: 2'd3};
      default: s = '{row: 2'd3, col: 2'd3};
    endcase
    return s;
  endfunction

  function automatic logic [DIV_W-1:0] row_count(input logic [1:0] r);
    case (r)
      2'd0: return 8'd160;
      2'd1: return 8'd146;
      2'd2: return 8'd132;
      default: return 8'd118;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] col_count(input logic [1:0] c);
    case (c)
      2'd0: return 8'd92;
      2'd1: return 8'd84;
      2'd2: return 8'd76;
      default: return 8'd68;
    endcase
  endfunction

  // first quadrant of a 32-point sine, k = 0..8, full scale 127
  function automatic logic [MAG_W-1:0] quarter_sine(input logic [3:0] k);
    case (k)
      4'd0: return 7'd0;
      4'd1: return 7'd25;
      4'd2: return 7'd49;
      4'd3: return 7'd71;
      4'd4: return 7'd90;
      4'd5: return 7'd106;
      4'd6: return 7'd117;
      4'd7: return 7'd125;
      default: return 7'd127;
    endcase
  endfunction
endpackage

// File: rtl/dtmf_tone_path.sv
module dtmf_tone_path
  import dtmf_pkg::*;
#(
  parameter int GAIN = 80
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    restart,
  input  logic [DIV_W-1:0]        seg_len,
  input  logic                    mute,
  output logic signed [AMP_W-1:0] sample
);
  logic [DIV_W-1:0]   div_cnt;
  logic [PHASE_W-1:0] phase;
  logic [MAG_W-1:0]   mag_q;
  logic               neg_q;
  logic [3:0]         fold_idx;
  logic [2*MAG_W-1:0] prod;
  logic [MAG_W-1:0]   scaled;
  logic signed [AMP_W-1:0] amp;

  // segment divider and 32-step phase counter
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_cnt <= '0;
      phase   <= '0;
    end else if (div_cnt == seg_len - 1'b1) begin
      div_cnt <= '0;
      phase   <= phase + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // fold the period onto the first quadrant
  always_comb begin
    if (phase[3:0] <= 4'd8) fold_idx = phase[3:0];
    else                    fold_idx = 4'(5'd16 - {1'b0, phase[3:0]});
  end

  // registered table read (ROM style)
  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else begin
      mag_q <= quarter_sine(fold_idx);
      neg_q <= phase[PHASE_W-1];
    end
  end

  always_comb begin
    prod   = mag_q * MAG_W'(GAIN);
    scaled = MAG_W'(prod >> MAG_W);
    amp    = $signed({2'b00, scaled});
  end

  always_ff @(posedge clk) begin
    if (rst || mute) sample <= '0;
    else             sample <= neg_q ? -amp : amp;
  end

  AST_DIV_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
    div_cnt < seg_len) else $error("divider past segment length"); // R2

  AST_PHASE_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!restart && div_cnt != seg_len - 1'b1) |=> $stable(phase))
    else $error("phase moved without divider wrap"); // R2
endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer #(
  parameter int BURST_TICKS = 182557
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_mode,
  output logic busy,
  output logic burst_on,
  output logic ready
);
  localparam int CNT_W = $clog2(2 * BURST_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(BURST_TICKS);
  localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(2 * BURST_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_BURST, S_PAUSE} tstate_t;
  tstate_t          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      len   <= SHORT_LEN;
      ready <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_BURST;
          cnt <= '0;
          len <= long_mode ? LONG_LEN : SHORT_LEN;
        end
        S_BURST: if (cnt == len - 1'b1) begin
          st  <= S_PAUSE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_PAUSE: if (cnt == len - 1'b1) begin
          st    <= S_IDLE;
          cnt   <= '0;
          ready <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign burst_on = (st == S_BURST);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready) else $error("ready held"); // R7

  AST_READY_AFTER_PAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(st == S_PAUSE)) else $error("ready without pause"); // R7

  AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt < len) else $error("interval overrun"); // R7

  AST_LONG_INTERVAL: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && long_mode) |=> len == LONG_LEN) else $error("long length"); // R8
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int SAMPLE_W    = 10,
  parameter int ROW_GAIN    = 80,
  parameter int COL_GAIN    = 101,
  parameter int BURST_TICKS = 182557
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [3:0]          wr_code,
  input  logic                tone_en,
  input  logic                burst_mode,
  input  logic                single_tone,
  input  logic                col_sel,
  input  logic                cp_mode,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                tone_active,
  output logic                tx_ready
);
  localparam logic [SAMPLE_W-1:0]   MID   = SAMPLE_W'(1) << (SAMPLE_W - 1);
  localparam logic signed [SAMPLE_W:0] MID_S = (SAMPLE_W+1)'(1) << (SAMPLE_W - 1);

  logic       busy, burst_on, accept;
  logic [3:0] code_q;
  tone_sel_t  sel;
  logic signed [AMP_W-1:0] path_sample [NUM_GROUPS];
  logic signed [SAMPLE_W:0] acc;

  assign accept = wr_en && !(burst_mode && busy);
  assign sel    = decode_digit(code_q);

  always_ff @(posedge clk) begin
    if (rst)         code_q <= '0;
    else if (accept) code_q <= wr_code;
  end

  dtmf_burst_timer #(.BURST_TICKS(BURST_TICKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (accept && burst_mode),
    .long_mode(cp_mode),
    .busy     (busy),
    .burst_on (burst_on),
    .ready    (tx_ready)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int G_GAIN = (g == 0) ? ROW_GAIN : COL_GAIN;
    logic [DIV_W-1:0] len;
    logic             mute;
    assign len  = (g == 0) ? row_count(sel.row) : col_count(sel.col);
    assign mute = single_tone && ((g == 0) ? col_sel : !col_sel);
    dtmf_tone_path #(.GAIN(G_GAIN)) u_path (
      .clk    (clk),
      .rst    (rst),
      .restart(accept),
      .seg_len(len),
      .mute   (mute),
      .sample (path_sample[g])
    );
  end

  always_comb
    acc = MID_S + (SAMPLE_W+1)'(path_sample[0]) + (SAMPLE_W+1)'(path_sample[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_active <= 1'b0;
      sample_out  <= MID;
    end else begin
      tone_active <= tone_en && (burst_mode ? burst_on : 1'b1);
      sample_out  <= tone_active ? SAMPLE_W'(acc) : MID;
    end
  end

  AST_REST_MID: assert property (@(posedge clk) disable iff (rst)
    !tone_active |=> sample_out == MID) else $error("not at rest level"); // R5

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (burst_mode && busy && wr_en) |=> $stable(code_q)) else $error("code changed while busy"); // R9
endmodule

// File: tb/tb_dtmf_synth.sv
module tb_dtmf_synth;
  localparam int SW    = 10;
  localparam int MID   = 512;
  localparam int TICKS = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_code = 4'd0;
  logic tone_en = 1'b0, burst_mode = 1'b0, single_tone = 1'b0, col_sel = 1'b0, cp_mode = 1'b0;
  logic [SW-1:0] sample_out;
  logic tone_active, tx_ready;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dtmf_synth #(.SAMPLE_W(SW), .BURST_TICKS(TICKS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .tone_en(tone_en),
    .burst_mode(burst_mode), .single_tone(single_tone), .col_sel(col_sel),
    .cp_mode(cp_mode), .sample_out(sample_out), .tone_active(tone_active),
    .tx_ready(tx_ready)
  );

  // code, row N, column N
  localparam int VEC [6][3] = '{
    '{1, 160, 92}, '{5, 146, 84}, '{9, 132, 76},
    '{0, 118, 68}, '{10, 118, 84}, '{15, 132, 68}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_code(input logic [3:0] c);
    @(negedge clk); wr_code = c; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // period between two rising mid-scale crossings, plus extremes inside it
  task automatic measure(output int per, output int mx, output int mn);
    int prev;
    int cur;
    int guard;
    prev = sample_out; guard = 0;
    while (guard < 20000) begin
      @(negedge clk); cur = sample_out; guard++;
      if (prev == MID && cur > MID) break;
      prev = cur;
    end
    prev = cur; per = 0; mx = cur; mn = cur;
    while (guard < 40000) begin
      @(negedge clk); cur = sample_out; per++; guard++;
      if (cur > mx) mx = cur;
      if (cur < mn) mn = cur;
      if (prev == MID && cur > MID) break;
      prev = cur;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, mx, mn, n, act_cnt;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(sample_out == MID, "R10 sample in reset", sample_out, MID);
    check(tone_active == 1'b0, "R10 gate in reset", tone_active, 0);
    check(tx_ready == 1'b0, "R10 ready in reset", tx_ready, 0);
    rst = 1'b0;

    // R1 R2 R3 R4: vector walk, single-tone period and swing per group
    tone_en = 1'b1; single_tone = 1'b1;
    for (int i = 0; i < 6; i++) begin
      col_sel = 1'b0;
      write_code(4'(VEC[i][0]));
      repeat (8) @(negedge clk);
      measure(per, mx, mn);
      check(per == 32 * VEC[i][1], $sformatf("R1 R2 row period code %0d", VEC[i][0]), per, 32 * VEC[i][1]);
      check(mx == MID + 79 && mn == MID - 79, "R4 R3 row swing", mx, MID + 79);
      col_sel = 1'b1;
      write_code(4'(VEC[i][0]));
      repeat (8) @(negedge clk);
      measure(per, mx, mn);
      check(per == 32 * VEC[i][2], $sformatf("R1 R2 column period code %0d", VEC[i][0]), per, 32 * VEC[i][2]);
      check(mx == MID + 100 && mn == MID - 100, "R4 R3 column swing", mx, MID + 100);
    end

    // dual tone: both groups, bounded by the sum of peaks
    single_tone = 1'b0;
    write_code(4'd5);
    mx = 0; mn = 1023;
    repeat (12000) begin
      @(negedge clk);
      if (sample_out > mx) mx = sample_out;
      if (sample_out < mn) mn = sample_out;
    end
    check(mx > MID + 100 && mx <= MID + 179, "R3 dual tone peak", mx, MID + 179);

    // R6 / R5: gate follows tone_en, rest at mid-scale
    tone_en = 1'b0;
    repeat (3) @(negedge clk);
    check(tone_active == 1'b0, "R6 gate closed", tone_active, 0);
    n = 0;
    repeat (60) begin @(negedge clk); if (sample_out != MID) n++; end
    check(n == 0, "R5 rest level while off", n, 0);
    @(negedge clk); tone_en = 1'b1;
    @(negedge clk);
    check(tone_active == 1'b1, "R6 gate reopens", tone_active, 1);

    // R7 burst timing
    burst_mode = 1'b1; single_tone = 1'b1; col_sel = 1'b0;
    repeat (4) @(negedge clk);
    wr_code = 4'd1; wr_en = 1'b1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    n = 0; act_cnt = 0;
    while (n < 10 * TICKS) begin
      @(posedge clk); @(negedge clk); n++;
      if (tone_active) act_cnt++;
      if (n == 10) begin wr_code = 4'd0; wr_en = 1'b1; end   // R9 write while busy
      if (n == 11) wr_en = 1'b0;
      if (n == TICKS + 20) begin wr_code = 4'd9; wr_en = 1'b1; end // R9 write in pause
      if (n == TICKS + 21) wr_en = 1'b0;
      if (tx_ready) break;
    end
    check(n == 2 * TICKS, "R7 ready delay", n, 2 * TICKS);
    check(act_cnt == TICKS, "R7 burst length", act_cnt, TICKS);
    @(posedge clk); @(negedge clk);
    check(tx_ready == 1'b0, "R7 ready single cycle", tx_ready, 0);

    // R9: dropped writes left code 1 (row count 160) in place
    burst_mode = 1'b0;
    measure(per, mx, mn);
    measure(per, mx, mn);
    check(per == 32 * 160, "R9 busy write ignored", per, 32 * 160);

    // R8 long interval
    burst_mode = 1'b1; cp_mode = 1'b1;
    repeat (4) @(negedge clk);
    wr_code = 4'd7; wr_en = 1'b1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    n = 0; act_cnt = 0;
    while (n < 10 * TICKS) begin
      @(posedge clk); @(negedge clk); n++;
      if (tone_active) act_cnt++;
      if (tx_ready) break;
    end
    check(n == 4 * TICKS, "R8 long ready delay", n, 4 * TICKS);
    check(act_cnt == 2 * TICKS, "R8 long burst length", act_cnt, 2 * TICKS);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule